// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is a bus-master DMA sequencer. It moves the contents of a local sector buffer to or from host memory, and host memory is described by a table of descriptors in memory. A start pulse latches the table base pointer, the direction and the number of bytes waiting in the buffer. The walker then fetches descriptors one at a time through a simple read port. It cuts each described region into burst requests on a request port that uses a valid/ready handshake, and each request carries the host address, the burst length, the byte offset into the sector buffer and the direction.

A descriptor is 8 bytes. The fetch port returns it as one 64-bit word, assembled little-endian: bits 31:0 hold the physical address of the region, and bits 63:32 hold the control word. A run ends in one of two ways. If the buffer is fully drained, a one-cycle `done` pulse is raised. If the table runs out first, a one-cycle `tbl_end` pulse is raised. The table runs out when the last region has been consumed, or when the fetch pointer has walked a full page of descriptors from the base.

The sequencer has six states:
- IDLE waits for `start`.
- EVAL decides what to do next.
- FETCH holds a descriptor read until it is acknowledged.
- BURST holds a data request until it is accepted.
- DRAINED and TBLEND each last one cycle, produce the matching pulse and return to IDLE.

The transitions are:
- IDLE→EVAL on `start`.
- EVAL→DRAINED when no buffer bytes remain.
- EVAL→TBLEND when the current region is empty and either it was flagged final or the page guard is reached.
- EVAL→FETCH when the current region is empty and the table may continue.
- EVAL→BURST when the current region still has bytes.
- FETCH→EVAL on `dsc_ack`.
- BURST→EVAL on `mem_ready`.
- DRAINED→IDLE and TBLEND→IDLE unconditionally.

Top module: `sg_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `dsc_req`, `mem_valid`, `done` and `tbl_end` are all low.
- R2: Descriptors are fetched at the latched base, then at base+8, base+16 and so on. In `dsc_rdata`, bits 31:0 are the region address and bits 63:32 are the control word.
- R3: The region length is control bits 15:0 with bit 0 forced to zero. A resulting length of zero means 65536 bytes.
- R4: Each burst length is the smallest of three values: the buffer bytes left, the region bytes left and MAX_BURST. Successive bursts advance the host address and the buffer offset by the previous length.
- R5: Control bit 31 flags the final region. Once that region is consumed with buffer bytes still left, `tbl_end` pulses for one cycle and no further fetch is made.
- R6: When the current region is consumed and the fetch pointer is PAGE_BYTES (4096) or more past the base, the walk ends with `tbl_end` and no further fetch is made.
- R7: When the buffer count reaches zero, `done` pulses for one cycle and no further fetch or burst is made, even if region bytes remain. A start with a count of zero gives `done` with no fetch.
- R8: A `start` pulse while `busy` is high has no effect on the addresses, lengths or direction of the run in progress.
- R9: Every start reloads the fetch pointer from `tbl_base` and discards any region left over from an earlier run.
- R10: A pending request keeps its address and length stable until it is accepted. A descriptor read and a data burst are never requested in the same cycle.
- R11: `mem_write` equals the `to_host` value latched at start (1 means buffer to host) for every burst of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| to_host | input | 1 | 1: buffer to host memory, 0: host memory to buffer |
| tbl_base | input | 32 | Descriptor table base address |
| buf_bytes | input | CNT_W | Bytes to move in this run |
| busy | output | 1 | A run is in progress |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | 32 | Descriptor read address |
| dsc_ack | input | 1 | Descriptor data valid; completes the read |
| dsc_rdata | input | 64 | Descriptor: [31:0] address, [63:32] control |
| mem_valid | output | 1 | Data burst request valid |
| mem_ready | input | 1 | Data burst accepted |
| mem_write | output | 1 | Burst direction (1 = write host memory) |
| mem_addr | output | 32 | Host address of the burst |
| mem_len | output | BURST_W | Burst length in bytes |
| mem_buf_off | output | CNT_W | Sector buffer byte offset of the burst |
| done | output | 1 | One-cycle pulse: buffer drained |
| tbl_end | output | 1 | One-cycle pulse: table exhausted first |

## Verification
The page guard is the hardest exit to reach from the ports, because it needs a table of more than 512 descriptors with none of them flagged final. The stimulus therefore builds a table of 520 two-byte regions and a buffer larger than those regions can absorb. The scoreboard then expects exactly 512 fetches followed by `tbl_end`. A second hard case is leftover region state across runs. A run is ended early by a short buffer, and the next start must fetch from the base again rather than resume mid-region. A stray `start` is also injected mid-run, with a different base and direction, to show it is ignored.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int SEG_LEN_W  = 17;
    localparam int DESC_BYTES = 8;

    typedef enum logic [2:0] {
        W_IDLE,
        W_EVAL,
        W_FETCH,
        W_BURST,
        W_DRAINED,
        W_TBLEND
    } walk_state_e;

    typedef struct packed {
        logic [31:0]          addr;
        logic [SEG_LEN_W-1:0] len;
        logic                 last;
    } region_t;

endpackage

// File: rtl/sgw_desc_unpack.sv
module sgw_desc_unpack
    import sgw_pkg::*;
(
    input  logic [63:0] raw,
    output region_t     region
);
    logic [15:0] len_even;

    always_comb begin
        len_even    = raw[47:32] & 16'hFFFE;
        region.addr = raw[31:0];
        region.len  = (len_even == 16'd0) ? SEG_LEN_W'(17'h10000) : {1'b0, len_even};
        region.last = raw[63];
    end
endmodule

// File: rtl/sgw_chunk_sizer.sv
module sgw_chunk_sizer
    import sgw_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int MAX_BURST = 512,
    parameter int BURST_W   = $clog2(MAX_BURST + 1)
) (
    input  logic [CNT_W-1:0]     left,
    input  logic [SEG_LEN_W-1:0] seg_len,
    output logic [BURST_W-1:0]   chunk
);
    localparam int W = 32;

    logic [W-1:0] l_w, s_w, m_w, c_w;

    always_comb begin
        l_w = W'(left);
        s_w = W'(seg_len);
        m_w = (l_w < s_w) ? l_w : s_w;
    end

    generate
        if (MAX_BURST < 65536) begin : g_cap
            assign c_w = (m_w > W'(MAX_BURST)) ? W'(MAX_BURST) : m_w;
        end else begin : g_nocap
            assign c_w = m_w;
        end
    endgenerate

    assign chunk = BURST_W'(c_w);
endmodule

// File: rtl/sgw_span_guard.sv
module sgw_span_guard #(
    parameter int PAGE_BYTES = 4096
) (
    input  logic [31:0] base,
    input  logic [31:0] fetch_ptr,
    output logic        spent
);
    logic [31:0] span;

    assign span  = fetch_ptr - base;
    assign spent = (span >= 32'(PAGE_BYTES));
endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sgw_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int MAX_BURST  = 512,
    parameter int PAGE_BYTES = 4096,
    parameter int BURST_W    = $clog2(MAX_BURST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               to_host,
    input  logic [31:0]        tbl_base,
    input  logic [CNT_W-1:0]   buf_bytes,
    output logic               busy,
    output logic               dsc_req,
    output logic [31:0]        dsc_addr,
    input  logic               dsc_ack,
    input  logic [63:0]        dsc_rdata,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic [31:0]        mem_addr,
    output logic [BURST_W-1:0] mem_len,
    output logic [CNT_W-1:0]   mem_buf_off,
    output logic               done,
    output logic               tbl_end
);
    walk_state_e state_q, state_d;

    logic [31:0]          base_q;
    logic [31:0]          fptr_q;
    logic [31:0]          seg_addr_q;
    logic [SEG_LEN_W-1:0] seg_len_q;
    logic                 seg_last_q;
    logic [CNT_W-1:0]     total_q;
    logic [CNT_W-1:0]     idx_q;
    logic                 dir_q;

    logic [CNT_W-1:0]     left;
    logic [BURST_W-1:0]   chunk;
    logic                 page_spent;
    region_t              fetched;

    assign left = total_q - idx_q;

    sgw_desc_unpack u_unpack (
        .raw    (dsc_rdata),
        .region (fetched)
    );

    sgw_chunk_sizer #(
        .CNT_W     (CNT_W),
        .MAX_BURST (MAX_BURST),
        .BURST_W   (BURST_W)
    ) u_sizer (
        .left    (left),
        .seg_len (seg_len_q),
        .chunk   (chunk)
    );

    sgw_span_guard #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_guard (
        .base      (base_q),
        .fetch_ptr (fptr_q),
        .spent     (page_spent)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:    if (start) state_d = W_EVAL;
            W_EVAL: begin
                if (left == '0)
                    state_d = W_DRAINED;
                else if (seg_len_q == '0)
                    state_d = (seg_last_q || page_spent) ? W_TBLEND : W_FETCH;
                else
                    state_d = W_BURST;
            end
            W_FETCH:   if (dsc_ack) state_d = W_EVAL;
            W_BURST:   if (mem_ready) state_d = W_EVAL;
            W_DRAINED: state_d = W_IDLE;
            W_TBLEND:  state_d = W_IDLE;
            default:   state_d = W_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            fptr_q     <= '0;
            seg_addr_q <= '0;
            seg_len_q  <= '0;
            seg_last_q <= 1'b0;
            total_q    <= '0;
            idx_q      <= '0;
            dir_q      <= 1'b0;
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    if (start) begin
                        base_q     <= tbl_base;
                        fptr_q     <= tbl_base;
                        seg_addr_q <= '0;
                        seg_len_q  <= '0;
                        seg_last_q <= 1'b0;
                        total_q    <= buf_bytes;
                        idx_q      <= '0;
                        dir_q      <= to_host;
                    end
                end
                W_FETCH: begin
                    if (dsc_ack) begin
                        seg_addr_q <= fetched.addr;
                        seg_len_q  <= fetched.len;
                        seg_last_q <= fetched.last;
                        fptr_q     <= fptr_q + 32'(DESC_BYTES);
                    end
                end
                W_BURST: begin
                    if (mem_ready) begin
                        seg_addr_q <= seg_addr_q + 32'(chunk);
                        seg_len_q  <= seg_len_q - SEG_LEN_W'(chunk);
                        idx_q      <= idx_q + CNT_W'(chunk);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != W_IDLE);
        dsc_req     = (state_q == W_FETCH);
        dsc_addr    = fptr_q;
        mem_valid   = (state_q == W_BURST);
        mem_write   = dir_q;
        mem_addr    = seg_addr_q;
        mem_len     = chunk;
        mem_buf_off = idx_q;
        done        = (state_q == W_DRAINED);
        tbl_end     = (state_q == W_TBLEND);
    end
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int CNT_W     = 20,
    parameter int MAX_BURST = 512,
    parameter int BURST_W   = $clog2(MAX_BURST + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               dsc_req,
    input logic [31:0]        dsc_addr,
    input logic               dsc_ack,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic [31:0]        mem_addr,
    input logic [BURST_W-1:0] mem_len,
    input logic [CNT_W-1:0]   mem_buf_off,
    input logic               done,
    input logic               tbl_end
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_valid && !dsc_req && !done && !tbl_end));

    assert_burst_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_len != '0) && (32'(mem_len) <= 32'(MAX_BURST)));

    assert_end_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_end |=> !tbl_end);

    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && tbl_end));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done && !tbl_end) |=> busy);

    assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_len) && $stable(mem_buf_off)));

    assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_req && !dsc_ack) |=> (dsc_req && $stable(dsc_addr)));

    assert_single_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && dsc_req));
endmodule

bind sg_walker sgw_checker #(
    .CNT_W     (CNT_W),
    .MAX_BURST (MAX_BURST),
    .BURST_W   (BURST_W)
) u_sgw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .dsc_req     (dsc_req),
    .dsc_addr    (dsc_addr),
    .dsc_ack     (dsc_ack),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_len     (mem_len),
    .mem_buf_off (mem_buf_off),
    .done        (done),
    .tbl_end     (tbl_end)
);

// File: tb/sg_walker_bench.sv
module sg_walker_bench;
    localparam int CNT_W     = 20;
    localparam int MAX_BURST = 512;
    localparam int PAGE      = 4096;
    localparam int BURST_W   = $clog2(MAX_BURST + 1);
    localparam int TBL_N     = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic to_host = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [CNT_W-1:0] buf_bytes = '0;
    logic busy, dsc_req, mem_valid, mem_write, done, tbl_end;
    logic [31:0] dsc_addr, mem_addr;
    logic dsc_ack = 1'b0;
    logic [63:0] dsc_rdata = '0;
    logic mem_ready = 1'b0;
    logic [BURST_W-1:0] mem_len;
    logic [CNT_W-1:0] mem_buf_off;

    always #5 clk = ~clk;

    sg_walker #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST), .PAGE_BYTES(PAGE)) u_sg_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .to_host(to_host),
        .tbl_base(tbl_base), .buf_bytes(buf_bytes), .busy(busy),
        .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack),
        .dsc_rdata(dsc_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_buf_off(mem_buf_off), .done(done), .tbl_end(tbl_end)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] l;
        logic [31:0] o;
        logic        w;
    } beat_t;

    logic [31:0] t_addr [0:TBL_N-1];
    logic [31:0] t_ctl  [0:TBL_N-1];
    logic [31:0] mem_base = '0;

    beat_t       exp_q[$];
    logic [31:0] fexp_q[$];
    int  exp_outcome = 0;   // 1 = drained, 2 = table end
    bit  run_over = 1'b0;
    int  nchk = 0;
    int  nfail = 0;
    int  cyc = 0;
    int  dwait = 0;
    bit  finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic clear_table();
        for (int i = 0; i < TBL_N; i++) begin
            t_addr[i] = '0;
            t_ctl[i]  = '0;
        end
    endtask

    // scoreboard driver: expected fetches, bursts and outcome from the rules
    task automatic build_expected(input logic [31:0] base, input int nbytes, input bit dir);
        int left, idx, clen, c, d;
        logic [31:0] fp, caddr;
        bit last;
        left = nbytes; idx = 0; fp = base; clen = 0; caddr = '0; last = 1'b0;
        exp_q.delete(); fexp_q.delete();
        forever begin
            if (left == 0) begin exp_outcome = 1; break; end
            if (clen == 0) begin
                if (last || ((fp - base) >= 32'(PAGE))) begin exp_outcome = 2; break; end
                fexp_q.push_back(fp);
                d = int'((fp - base) >> 3);
                caddr = t_addr[d];
                clen  = int'(t_ctl[d][15:0] & 16'hFFFE);
                if (clen == 0) clen = 65536;
                last = t_ctl[d][31];
                fp = fp + 32'd8;
            end
            c = (left < clen) ? left : clen;
            if (c > MAX_BURST) c = MAX_BURST;
            exp_q.push_back('{a: caddr, l: 32'(c), o: 32'(idx), w: dir});
            caddr = caddr + 32'(c);
            clen -= c; left -= c; idx += c;
        end
    endtask

    task automatic run(input logic [31:0] base, input int nbytes, input bit dir,
                       input bit inject, input string tag);
        build_expected(base, nbytes, dir);
        mem_base = base;
        run_over = 1'b0;
        @(negedge clk);
        tbl_base = base; buf_bytes = CNT_W'(nbytes); to_host = dir; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (6) @(negedge clk);
            check(busy === 1'b1, "R8", "busy before stray start", longint'(busy), 1);
            tbl_base = base + 32'h100; to_host = !dir; buf_bytes = CNT_W'(8); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (run_over);
        @(negedge clk);
        check(exp_q.size() == 0, tag, "bursts left unseen", exp_q.size(), 0);
        check(fexp_q.size() == 0, tag, "fetches left unseen", fexp_q.size(), 0);
        check(busy === 1'b0, "R1", "idle after run", longint'(busy), 0);
    endtask

    // monitor: responders and comparisons, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            mem_ready = ((cyc % 3) != 1);
            if (dsc_req) begin
                dwait++;
                if (dwait >= 2) begin
                    int d;
                    d = int'((dsc_addr - mem_base) >> 3);
                    dsc_rdata = (d >= 0 && d < TBL_N) ? {t_ctl[d], t_addr[d]} : 64'd0;
                    dsc_ack = 1'b1;
                    dwait = 0;
                    if (fexp_q.size() == 0)
                        check(1'b0, "R2 R5 R6 R7", "unexpected fetch", dsc_addr, 0);
                    else begin
                        logic [31:0] ef;
                        ef = fexp_q.pop_front();
                        check(dsc_addr == ef, "R2 R9", "fetch address", dsc_addr, ef);
                    end
                end else dsc_ack = 1'b0;
            end else begin
                dsc_ack = 1'b0;
                dwait = 0;
            end
            if (mem_valid && mem_ready) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R7", "unexpected burst", mem_addr, 0);
                else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.a, "R4", "burst address", mem_addr, e.a);
                    check(32'(mem_len) == e.l, "R3 R4", "burst length", mem_len, e.l);
                    check(32'(mem_buf_off) == e.o, "R4", "buffer offset", mem_buf_off, e.o);
                    check(mem_write == e.w, "R11", "direction", mem_write, e.w);
                end
            end
            if (done) begin
                check(exp_outcome == 1, "R7", "drained outcome", 1, exp_outcome);
                run_over = 1'b1;
            end
            if (tbl_end) begin
                check(exp_outcome == 2, "R5 R6", "table end outcome", 2, exp_outcome);
                run_over = 1'b1;
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            check(1'b0, "R1", "watchdog expired", cyc, 150000);
            summary();
        end
    end

    initial begin
        clear_table();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1", "busy in reset", longint'(busy), 0);
        check(mem_valid === 1'b0 && dsc_req === 1'b0, "R1", "requests in reset",
              longint'({mem_valid, dsc_req}), 0);
        check(done === 1'b0 && tbl_end === 1'b0, "R1", "pulses in reset",
              longint'({done, tbl_end}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy === 1'b0, "R1", "idle after reset", longint'(busy), 0);

        // R2 R4 R7 R11: two regions, exact fit, buffer to host
        clear_table();
        t_addr[0] = 32'h0001_0000; t_ctl[0] = 32'h0000_0300;
        t_addr[1] = 32'h0002_0010; t_ctl[1] = 32'h8000_0100;
        run(32'h0000_1000, 1024, 1'b1, 1'b0, "R2 R7");

        // R5 R11: buffer larger than the table, host to buffer
        run(32'h0000_1000, 2000, 1'b0, 1'b0, "R5");

        // R3: odd length, zero length (65536), final flag
        clear_table();
        t_addr[0] = 32'h0010_0000; t_ctl[0] = 32'h0000_0003;
        t_addr[1] = 32'h0020_0000; t_ctl[1] = 32'h0000_0000;
        t_addr[2] = 32'h0040_0000; t_ctl[2] = 32'h8000_1001;
        run(32'h0000_2000, 70000, 1'b1, 1'b0, "R3 R5");

        // R7 then R9: short buffer leaves region bytes, restart fetches base again
        clear_table();
        t_addr[0] = 32'h0005_0000; t_ctl[0] = 32'h0000_03E8;
        t_addr[1] = 32'h0006_0000; t_ctl[1] = 32'h8000_0800;
        run(32'h0000_3000, 300, 1'b1, 1'b0, "R7");
        run(32'h0000_3000, 600, 1'b0, 1'b0, "R9");

        // R7: zero count drains at once with no fetch
        run(32'h0000_3000, 0, 1'b1, 1'b0, "R7");

        // R8: stray start mid-run
        run(32'h0000_3000, 1800, 1'b1, 1'b1, "R8");

        // R6: page guard after 512 descriptors, none flagged final
        clear_table();
        for (int i = 0; i < 520; i++) begin
            t_addr[i] = 32'h0100_0000 + 32'(i) * 32'h100;
            t_ctl[i]  = 32'h0000_0002;
        end
        run(32'h0000_8000, 4000, 1'b1, 1'b0, "R6");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule